// File: doc/BRIEF.md
# Strongest-Signal Tracking Priority Queue

This block tracks wireless access points from a stream of beacon observations. Each observation carries a 16-bit access-point index and a 12-bit signal-quality sample. Each tracked access point keeps a four-deep sample history, and the block ranks access points by the average of that history. Seven entries are tracked in all. Three form a ranked set, ordered strongest first, which a downstream position solver reads. The other four form a recency queue of candidates that can be promoted into the ranked set.

One observation is taken at a time through a ready/valid handshake. Once accepted, it runs through three internal steps, while ready stays low. The first step updates the history and the queue order. The second re-sorts the ranked set. The third promotes a candidate if one is stronger than the weakest ranked entry and then re-sorts again. The ranked outputs carry a valid flag that is high only while the block is idle and all three ranked slots hold distinct access points.

Top module: `sig_top3_tracker`

## Requirements
- R1: While rst_n is low and after it is released, obs_ready is 1, top_valid is 0, and all ranked identifiers and averages read 0.
- R2: An observation is accepted on a rising clock edge where obs_valid and obs_ready are both 1. obs_ready then stays 0 for exactly three cycles and returns to 1. Nothing changes while the block is idle without an accepted observation.
- R3: The average reported for an access point is the floor of the sum of its four history slots divided by four. A new sample for an already-tracked access point replaces its oldest slot.
- R4: A sample for an untracked access point fills all four of its history slots, so its first average equals that sample.
- R5: top_valid is 1 only when obs_ready is 1 and all three ranked slots hold valid, distinct access points.
- R6: Ranked slot 0 holds the highest average and slot 2 the lowest. When two averages are equal, the entry that held the higher slot before the re-sort keeps it.
- R7: After each update, the valid queue entry with the highest average is found, with the most recently used entry winning a tie. If its average is strictly greater than the weakest ranked average, or if that ranked slot is empty, the two entries swap, and the demoted entry takes the vacated queue position.
- R8: An untracked access point enters the front of the recency queue, and the entry at the back of the queue is dropped. A queue entry that receives a sample moves to the front. A dropped access point that is seen again is treated as new.
- R9: Samples of 4095 average to 4095 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | Observation present |
| obs_ready | output | 1 | Block idle and able to accept an observation |
| obs_id | input | 16 | Access-point index of the observation |
| obs_snr | input | 12 | Signal-quality sample of the observation |
| top_valid | output | 1 | Ranked set complete and stable |
| top0_id | output | 16 | Strongest access point |
| top0_avg | output | 12 | Average of the strongest access point |
| top1_id | output | 16 | Second access point |
| top1_avg | output | 12 | Average of the second access point |
| top2_id | output | 16 | Third access point |
| top2_avg | output | 12 | Average of the third access point |

## Verification
The hardest state to reach from the ports is eviction. It needs three ranked entries that all outrank four queued entries, and then a fifth weak newcomer that pushes out the oldest queued entry. The directed sequence builds this state in a known order. It first demotes a ranked entry into the queue by lowering its average below a queued candidate. It then pushes three weak newcomers, so that the demoted entry falls off the back. When that access point reappears, its average equals its new sample exactly, and this would not be so if it were still tracked. Random traffic from a pool of twelve indices, with occasional full-scale and zero samples, then exercises promotions, ties and queue reordering against a bench model.

// File: rtl/sig_trk_pkg.sv
package sig_trk_pkg;
  localparam int ID_W   = 16;
  localparam int SMP_W  = 12;
  localparam int HIST   = 4;
  localparam int N_TOP  = 3;
  localparam int N_Q    = 4;
  localparam int N_ENT  = N_TOP + N_Q;
  localparam int HP_W   = $clog2(HIST);
  localparam int SUM_W  = SMP_W + HP_W;
  localparam int KEY_W  = SMP_W + 1;
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int RK_W   = $clog2(N_TOP);

  typedef struct packed {
    logic                       vld;
    logic [HP_W-1:0]            ptr;
    logic [HIST-1:0][SMP_W-1:0] smp;
    logic [ID_W-1:0]            id;
  } ent_t;

  function automatic logic [SMP_W-1:0] ent_avg(ent_t e);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int k = 0; k < HIST; k++) s = s + SUM_W'(e.smp[k]);
    return s[SUM_W-1:HP_W];
  endfunction

  function automatic logic [KEY_W-1:0] ent_key(ent_t e);
    return {e.vld, ent_avg(e)};
  endfunction
endpackage

// File: rtl/sig_match.sv
module sig_match
  import sig_trk_pkg::*;
(
  input  ent_t [N_ENT-1:0] ents_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ents_i[i].vld && ents_i[i].id == id_i) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sig_qbest.sv
module sig_qbest
  import sig_trk_pkg::*;
(
  input  ent_t [N_ENT-1:0] ents_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [KEY_W-1:0] best_k;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best_k  = '0;
    // walk back to front so the most recent entry wins a tie
    for (int q = N_ENT - 1; q >= N_TOP; q--) begin
      if (ents_i[q].vld && (!found_o || ent_key(ents_i[q]) >= best_k)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(q);
        best_k  = ent_key(ents_i[q]);
      end
    end
  end
endmodule

// File: rtl/sig_rank_sort.sv
module sig_rank_sort
  import sig_trk_pkg::*;
(
  input  ent_t [N_TOP-1:0] srt_i,
  output ent_t [N_TOP-1:0] srt_o
);
  logic [RK_W-1:0] rk [N_TOP];

  always_comb begin
    int r;
    for (int i = 0; i < N_TOP; i++) begin
      r = 0;
      for (int j = 0; j < N_TOP; j++) begin
        if (j != i) begin
          if (ent_key(srt_i[j]) > ent_key(srt_i[i]) ||
              (j < i && ent_key(srt_i[j]) == ent_key(srt_i[i])))
            r = r + 1;
        end
      end
      rk[i] = RK_W'(r);
    end
    srt_o = '0;
    for (int i = 0; i < N_TOP; i++) srt_o[rk[i]] = srt_i[i];
  end
endmodule

// File: rtl/sig_top3_tracker.sv
module sig_top3_tracker
  import sig_trk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             obs_valid,
  output logic             obs_ready,
  input  logic [ID_W-1:0]  obs_id,
  input  logic [SMP_W-1:0] obs_snr,
  output logic             top_valid,
  output logic [ID_W-1:0]  top0_id,
  output logic [SMP_W-1:0] top0_avg,
  output logic [ID_W-1:0]  top1_id,
  output logic [SMP_W-1:0] top1_avg,
  output logic [ID_W-1:0]  top2_id,
  output logic [SMP_W-1:0] top2_avg
);
  typedef enum logic [1:0] {ST_IDLE, ST_UPD, ST_SORT, ST_PROMO} st_e;

  st_e              st_q, st_d;
  ent_t [N_ENT-1:0] ent_q, ent_d;
  logic [ID_W-1:0]  id_q;
  logic [SMP_W-1:0] snr_q;
  logic             cap_en, ent_en;

  logic             hit, q_found, do_swap;
  logic [IDX_W-1:0] hit_idx, q_idx, src;
  ent_t             ins;
  ent_t [N_TOP-1:0] srt_in, srt_out;

  sig_match u_match (.ents_i(ent_q), .id_i(id_q), .hit_o(hit), .idx_o(hit_idx));
  sig_qbest u_qbest (.ents_i(ent_q), .found_o(q_found), .idx_o(q_idx));
  sig_rank_sort u_sort (.srt_i(srt_in), .srt_o(srt_out));

  // promotion candidate compared against the weakest ranked slot
  assign do_swap = q_found && (ent_key(ent_q[q_idx]) > ent_key(ent_q[N_TOP-1]));

  always_comb begin
    srt_in = ent_q[N_TOP-1:0];
    if (st_q == ST_PROMO && do_swap) srt_in[N_TOP-1] = ent_q[q_idx];
  end

  // entry written back by the update step
  always_comb begin
    if (hit) begin
      ins = ent_q[hit_idx];
      ins.smp[ins.ptr] = snr_q;
      ins.ptr = ins.ptr + 1'b1;
    end else begin
      ins.vld = 1'b1;
      ins.ptr = '0;
      ins.id  = id_q;
      for (int k = 0; k < HIST; k++) ins.smp[k] = snr_q;
    end
    src = hit ? hit_idx : IDX_W'(N_ENT - 1);
  end

  always_comb begin
    st_d   = st_q;
    ent_d  = ent_q;
    cap_en = 1'b0;
    ent_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (obs_valid) begin
          cap_en = 1'b1;
          st_d   = ST_UPD;
        end
      end
      ST_UPD: begin
        ent_en = 1'b1;
        if (hit && hit_idx < IDX_W'(N_TOP)) begin
          ent_d[hit_idx] = ins;
        end else begin
          for (int q = N_TOP + 1; q < N_ENT; q++)
            if (q <= int'(src)) ent_d[q] = ent_q[q-1];
          ent_d[N_TOP] = ins;
        end
        st_d = ST_SORT;
      end
      ST_SORT: begin
        ent_en = 1'b1;
        ent_d[N_TOP-1:0] = srt_out;
        st_d = ST_PROMO;
      end
      ST_PROMO: begin
        ent_en = 1'b1;
        ent_d[N_TOP-1:0] = srt_out;
        if (do_swap) ent_d[q_idx] = ent_q[N_TOP-1];
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ent_q <= '0;
      id_q  <= '0;
      snr_q <= '0;
    end else begin
      st_q <= st_d;
      if (ent_en) ent_q <= ent_d;
      if (cap_en) begin
        id_q  <= obs_id;
        snr_q <= obs_snr;
      end
    end
  end

  assign obs_ready = (st_q == ST_IDLE);
  assign top_valid = obs_ready && ent_q[0].vld && ent_q[1].vld && ent_q[2].vld;
  assign top0_id   = ent_q[0].id;
  assign top1_id   = ent_q[1].id;
  assign top2_id   = ent_q[2].id;
  assign top0_avg  = ent_avg(ent_q[0]);
  assign top1_avg  = ent_avg(ent_q[1]);
  assign top2_avg  = ent_avg(ent_q[2]);
endmodule

// File: rtl/sig_top3_checker.sv
module sig_top3_checker
  import sig_trk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             obs_valid,
  input logic             obs_ready,
  input logic             top_valid,
  input logic [ID_W-1:0]  top0_id,
  input logic [SMP_W-1:0] top0_avg,
  input logic [ID_W-1:0]  top1_id,
  input logic [SMP_W-1:0] top1_avg,
  input logic [ID_W-1:0]  top2_id,
  input logic [SMP_W-1:0] top2_avg
);
  a_r2_busy_three: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obs_ready) |=> !obs_ready ##1 !obs_ready ##1 obs_ready);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_ready && !obs_valid) |=> ($stable(top0_id) && $stable(top1_id) &&
                                   $stable(top2_id) && $stable(top0_avg) &&
                                   $stable(top1_avg) && $stable(top2_avg)));

  a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> obs_ready);

  a_r5_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (top0_id != top1_id && top1_id != top2_id && top0_id != top2_id));

  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (top0_avg >= top1_avg && top1_avg >= top2_avg));
endmodule

bind sig_top3_tracker sig_top3_checker u_chk (
  .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_ready(obs_ready),
  .top_valid(top_valid), .top0_id(top0_id), .top0_avg(top0_avg),
  .top1_id(top1_id), .top1_avg(top1_avg), .top2_id(top2_id), .top2_avg(top2_avg)
);

// File: tb/tb_sig_top3_tracker.sv
module tb_sig_top3_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        obs_valid;
  logic        obs_ready;
  logic [15:0] obs_id;
  logic [11:0] obs_snr;
  logic        top_valid;
  logic [15:0] top0_id, top1_id, top2_id;
  logic [11:0] top0_avg, top1_avg, top2_avg;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sig_top3_tracker dut (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_ready(obs_ready),
    .obs_id(obs_id), .obs_snr(obs_snr), .top_valid(top_valid),
    .top0_id(top0_id), .top0_avg(top0_avg), .top1_id(top1_id), .top1_avg(top1_avg),
    .top2_id(top2_id), .top2_avg(top2_avg)
  );

  typedef struct {
    bit v;
    int p;
    int s[4];
    int id;
  } mod_ent_t;

  mod_ent_t mdl[7];

  function automatic int m_avg(mod_ent_t e);
    return (e.s[0] + e.s[1] + e.s[2] + e.s[3]) / 4;
  endfunction

  function automatic int m_key(mod_ent_t e);
    return (e.v ? 8192 : 0) + m_avg(e);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < 7; i++) begin
      mdl[i].v = 0; mdl[i].p = 0; mdl[i].id = 0;
      for (int k = 0; k < 4; k++) mdl[i].s[k] = 0;
    end
  endtask

  task automatic m_sort();
    mod_ent_t t;
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < 2; i++)
        if (m_key(mdl[i+1]) > m_key(mdl[i])) begin
          t = mdl[i]; mdl[i] = mdl[i+1]; mdl[i+1] = t;
        end
  endtask

  task automatic m_obs(int id, int snr);
    int hit = -1;
    int src;
    int best = -1;
    mod_ent_t ins, t;
    for (int i = 0; i < 7; i++) if (mdl[i].v && mdl[i].id == id) hit = i;
    if (hit >= 0) begin
      ins = mdl[hit];
      ins.s[ins.p] = snr;
      ins.p = (ins.p + 1) % 4;
    end else begin
      ins.v = 1; ins.p = 0; ins.id = id;
      for (int k = 0; k < 4; k++) ins.s[k] = snr;
    end
    if (hit >= 0 && hit < 3) mdl[hit] = ins;
    else begin
      src = (hit >= 0) ? hit : 6;
      for (int q = src; q > 3; q--) mdl[q] = mdl[q-1];
      mdl[3] = ins;
    end
    m_sort();
    for (int q = 3; q < 7; q++)
      if (mdl[q].v && (best < 0 || m_avg(mdl[q]) > m_avg(mdl[best]))) best = q;
    if (best >= 0 && m_key(mdl[best]) > m_key(mdl[2])) begin
      t = mdl[2]; mdl[2] = mdl[best]; mdl[best] = t;
    end
    m_sort();
  endtask

  task automatic send(int id, int snr);
    int busy = 0;
    @(negedge clk);
    obs_valid = 1'b1;
    obs_id    = 16'(id);
    obs_snr   = 12'(snr);
    @(posedge clk);
    #1;
    obs_valid = 1'b0;
    while (!obs_ready) begin
      busy++;
      @(posedge clk);
      #1;
    end
    chk("R2 busy cycles", busy, 3);
    m_obs(id, snr);
    #3;
    chk("R5 top_valid", int'(top_valid), int'(mdl[0].v && mdl[1].v && mdl[2].v));
    chk("R6 top0_id", int'(top0_id), mdl[0].id);
    chk("R6 top1_id", int'(top1_id), mdl[1].id);
    chk("R6 top2_id", int'(top2_id), mdl[2].id);
    chk("R6 top0_avg", int'(top0_avg), m_avg(mdl[0]));
    chk("R6 top1_avg", int'(top1_avg), m_avg(mdl[1]));
    chk("R6 top2_avg", int'(top2_avg), m_avg(mdl[2]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int pick;
    int snr;
    void'($urandom(32'd4242));
    m_clear();
    rst_n = 1'b0; obs_valid = 1'b0; obs_id = '0; obs_snr = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 ready in reset", int'(obs_ready), 1);
    chk("R1 valid in reset", int'(top_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(obs_ready), 1);
    chk("R1 valid after reset", int'(top_valid), 0);
    chk("R1 top0_id after reset", int'(top0_id), 0);
    chk("R1 top2_avg after reset", int'(top2_avg), 0);

    send(16'h0A01, 1000);
    chk("R4 first avg equals sample", int'(top0_avg), 1000);
    chk("R5 one entry not valid", int'(top_valid), 0);
    send(16'h0A02, 800);
    chk("R5 two entries not valid", int'(top_valid), 0);
    send(16'h0A03, 600);
    chk("R5 three entries valid", int'(top_valid), 1);
    send(16'h0A03, 1000);
    chk("R3 oldest slot replaced", int'(top2_avg), 700);
    send(16'h0A04, 650);
    chk("R7 weaker candidate stays queued", int'(top2_id), 16'h0A03);
    send(16'h0A03, 0);
    chk("R7 candidate promoted id", int'(top2_id), 16'h0A04);
    chk("R7 candidate promoted avg", int'(top2_avg), 650);
    send(16'h0A05, 800);
    chk("R6 tie keeps holder", int'(top1_id), 16'h0A02);
    chk("R6 tie newcomer below", int'(top2_id), 16'h0A05);
    send(16'h0A06, 100);
    send(16'h0A07, 110);
    send(16'h0A08, 120);
    send(16'h0A03, 2000);
    chk("R8 evicted entry re-enters fresh id", int'(top0_id), 16'h0A03);
    chk("R8 evicted entry re-enters fresh avg", int'(top0_avg), 2000);
    send(16'h0BFF, 4095);
    send(16'h0BFF, 4095);
    chk("R9 full-scale average", int'(top0_avg), 4095);
    chk("R9 full-scale id", int'(top0_id), 16'h0BFF);

    for (int n = 0; n < 600; n++) begin
      pick = $urandom_range(0, 11);
      case ($urandom_range(0, 7))
        0: snr = 4095;
        1: snr = 0;
        default: snr = $urandom_range(0, 4095);
      endcase
      send(16'h0C00 + pick, snr);
    end

    // no accepted observation: outputs must hold
    @(negedge clk);
    pick = int'(top0_id);
    snr  = int'(top0_avg);
    repeat (5) @(negedge clk);
    chk("R2 idle holds top0_id", int'(top0_id), pick);
    chk("R2 idle holds top0_avg", int'(top0_avg), snr);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule